// File: doc/BRIEF.md
# Flash Status Poll Verifier

This block sits on the host side of a parallel flash device. It decides whether a program or erase operation that has already been launched has completed successfully. A single start pulse hands it three things: the byte that was programmed, an address the device will answer status reads on, and an idle gap length. The block then reads status bytes from that address over a simple one-request, one-response read port. It evaluates each byte with the ready-bit / time-limit-bit loop and finishes with a one-cycle done pulse and a held pass or fail result.

The loop works on two bits of each status byte. Bit 7 is the ready bit: it equals the true data bit once the operation has finished, and it shows the inverse while the operation is running. Bit 5 is the time-limit flag. The two bits can change in the same read, so a raised time-limit flag never leads straight to failure. The block first reads the byte once more and judges bit 7 again.

Bit 7 can settle before the lower bits do. For that reason, when the block passes it makes one more read and returns that byte as the verified data. For an erase, the caller supplies an expected byte of 0xFF, so the ready bit it waits for is 1. Sending the command sequences, and any recovery after a failure, are left to the caller.

Top module: `poll_verifier`

## Requirements
- R1: While reset is held low, rd_req_o, done_o, pass_o and fail_o are 0 and data_o is 0x00.
- R2: When start_i is sampled high while idle, the block captures addr_i, exp_byte_i and gap_i, and raises rd_req_o in the next cycle. Every read of the job puts the captured address on rd_addr_o.
- R3: A poll or recheck response whose bit 7 equals bit 7 of the expected byte counts as a successful comparison. The block then moves on to a verification read.
- R4: A poll response whose bit 7 differs from the expected bit and whose bit 5 is 0 leads to another poll read.
- R5: A poll response whose bit 7 differs and whose bit 5 is 1 leads to exactly one recheck read. If the recheck's bit 7 matches, the block goes on as in R3. Otherwise the job ends with fail_o = 1 and data_o = the recheck byte.
- R6: After a successful comparison, the block makes one extra read. Its byte appears on data_o with pass_o = 1.
- R7: Between a response cycle and the next read request there are exactly gap idle cycles. A gap of 0 puts the request in the cycle right after the response.
- R8: done_o is high for exactly one cycle, the cycle after the final response. pass_o and fail_o are never both high. The result holds until the next accepted start, which clears both in the following cycle.
- R9: A start_i pulse that arrives while a job is running is ignored. It does not change the address, the expected byte, the gap or the number of reads.
- R10: At most one read is outstanding. rd_req_o is never raised while a response is still awaited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| exp_byte_i | input | 8 | Byte that was programmed (0xFF for erase) |
| addr_i | input | AW | Valid address used for the status reads |
| gap_i | input | GW | Idle cycles between consecutive reads |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_vld_i | input | 1 | Read response valid |
| rd_data_i | input | 8 | Read response byte |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Held pass result |
| fail_o | output | 1 | Held fail result |
| data_o | output | 8 | Verified byte on pass, recheck byte on fail |

## Verification
The assertions check, on every cycle, the properties that depend only on the port sequence. They cover the single outstanding read, the address carried on each request, the one-cycle done pulse, the exclusive and held result, and a result being present whenever done is high. How each status byte is judged cannot be seen from one cycle. This covers the poll-again, recheck and verify steps, as well as the exact idle gap and a start being ignored mid-job. These show only in the bench's scenarios, where a behavioural status model replays chosen byte sequences at chosen latencies. A cycle-by-cycle reference model is compared against the outputs on every clock.

// File: rtl/pv_pkg.sv
// Package: shared types for the status poll verifier.
// Assumes: the status byte is at least 8 bits wide, so bits 7 and 5 exist.
package pv_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } pv_state_t;

    // Purpose of the read currently in flight
    typedef enum logic [1:0] {
        PH_POLL    = 2'd0,
        PH_RECHECK = 2'd1,
        PH_VERIFY  = 2'd2
    } pv_phase_t;

    // Verdict on one returned status byte
    typedef enum logic [2:0] {
        DEC_RETRY   = 3'd0,
        DEC_MATCH   = 3'd1,
        DEC_RECHECK = 3'd2,
        DEC_FAIL    = 3'd3,
        DEC_DONE    = 3'd4
    } pv_dec_t;

endpackage

// File: rtl/pv_status_eval.sv
// Module: pv_status_eval
// Turns one status byte into a verdict, given the phase of the read.
// Assumes: the byte is judged only in the cycle its response is valid.
module pv_status_eval
    import pv_pkg::*;
#(
    parameter int DW       = 8,
    parameter int RDY_BIT  = 7,
    parameter int TLIM_BIT = 5
) (
    input  logic [DW-1:0] byte_i,
    input  logic          exp_bit_i,
    input  pv_phase_t     phase_i,
    output pv_dec_t       dec_o
);

    logic rdy_match;
    logic tlim_set;

    assign rdy_match = (byte_i[RDY_BIT] == exp_bit_i);
    assign tlim_set  = byte_i[TLIM_BIT];

    // Map the phase and the two status bits onto a verdict
    always_comb begin
        if (phase_i == PH_VERIFY) begin
            dec_o = DEC_DONE;
        end else if (rdy_match) begin
            dec_o = DEC_MATCH;
        end else if (phase_i == PH_RECHECK) begin
            dec_o = DEC_FAIL;
        end else if (tlim_set) begin
            dec_o = DEC_RECHECK;
        end else begin
            dec_o = DEC_RETRY;
        end
    end

endmodule

// File: rtl/pv_gap_timer.sv
// Module: pv_gap_timer
// Down-counter that spaces out consecutive reads.
// Assumes: it is loaded only with a non-zero value; expire_o marks the last idle cycle.
module pv_gap_timer #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [GW-1:0] val_i,
    output logic          expire_o
);

    logic [GW-1:0] cnt_q;

    // Load on request, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == {{(GW-1){1'b0}}, 1'b1});

endmodule

// File: rtl/pv_job_regs.sv
// Module: pv_job_regs
// Captures the job parameters when a start is accepted and drives the read address.
// Assumes: accept_i is high only in an idle cycle with start sampled.
module pv_job_regs #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int GW      = 8,
    parameter int RDY_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] exp_i,
    input  logic [GW-1:0] gap_i,
    output logic [AW-1:0] addr_o,
    output logic          exp_bit_o,
    output logic [GW-1:0] gap_o,
    output logic          gap_zero_o
);

    // Hold the job parameters for the whole run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o    <= '0;
            exp_bit_o <= 1'b0;
            gap_o     <= '0;
        end else if (accept_i) begin
            addr_o    <= addr_i;
            exp_bit_o <= exp_i[RDY_BIT];
            gap_o     <= gap_i;
        end
    end

    assign gap_zero_o = (gap_o == '0);

endmodule

// File: rtl/pv_sequencer.sv
// Module: pv_sequencer
// Runs the read loop: issue, wait for the response, act on the verdict, wait out the gap.
// Assumes: exactly one response arrives for each request, never in the request cycle.
module pv_sequencer
    import pv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      rd_vld_i,
    input  pv_dec_t   dec_i,
    input  logic      gap_zero_i,
    input  logic      gap_expire_i,
    output pv_phase_t phase_o,
    output logic      accept_o,
    output logic      issue_o,
    output logic      gap_load_o,
    output logic      finish_o,
    output logic      finish_pass_o
);

    pv_state_t state_q, state_d;
    pv_phase_t phase_q, phase_d;
    logic      judge;

    assign judge    = (state_q == ST_WAIT) && rd_vld_i;
    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign issue_o  = (state_q == ST_ISSUE);
    assign phase_o  = phase_q;

    // Next state, next phase and the one-cycle strobes
    always_comb begin
        state_d       = state_q;
        phase_d       = phase_q;
        gap_load_o    = 1'b0;
        finish_o      = 1'b0;
        finish_pass_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ISSUE;
                    phase_d = PH_POLL;
                end
            end
            ST_ISSUE: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (judge) begin
                    if (dec_i == DEC_DONE) begin
                        finish_o      = 1'b1;
                        finish_pass_o = 1'b1;
                        state_d       = ST_IDLE;
                    end else if (dec_i == DEC_FAIL) begin
                        finish_o = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        if (dec_i == DEC_MATCH) begin
                            phase_d = PH_VERIFY;
                        end else if (dec_i == DEC_RECHECK) begin
                            phase_d = PH_RECHECK;
                        end
                        if (gap_zero_i) begin
                            state_d = ST_ISSUE;
                        end else begin
                            state_d    = ST_GAP;
                            gap_load_o = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_expire_i) begin
                    state_d = ST_ISSUE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_POLL;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/poll_verifier.sv
// Module: poll_verifier (top)
// Polls a flash status byte until the operation passes or fails, then verifies the data.
// Assumes: the caller supplies a valid status address and, for an erase, an expected byte of 0xFF.
module poll_verifier
    import pv_pkg::*;
#(
    parameter int AW = 16,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [7:0]    exp_byte_i,
    input  logic [AW-1:0] addr_i,
    input  logic [GW-1:0] gap_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_vld_i,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [7:0]    data_o
);

    localparam int DW       = 8;
    localparam int RDY_BIT  = DW - 1;
    localparam int TLIM_BIT = DW - 3;

    pv_phase_t phase;
    pv_dec_t   dec;
    logic      accept, issue, gap_load, gap_expire, finish, finish_pass;
    logic      exp_bit, gap_zero;
    logic [GW-1:0] gap_val;

    pv_job_regs #(.AW(AW), .DW(DW), .GW(GW), .RDY_BIT(RDY_BIT)) u_job (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .addr_i     (addr_i),
        .exp_i      (exp_byte_i),
        .gap_i      (gap_i),
        .addr_o     (rd_addr_o),
        .exp_bit_o  (exp_bit),
        .gap_o      (gap_val),
        .gap_zero_o (gap_zero)
    );

    pv_status_eval #(.DW(DW), .RDY_BIT(RDY_BIT), .TLIM_BIT(TLIM_BIT)) u_eval (
        .byte_i    (rd_data_i),
        .exp_bit_i (exp_bit),
        .phase_i   (phase),
        .dec_o     (dec)
    );

    pv_gap_timer #(.GW(GW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (gap_load),
        .val_i    (gap_val),
        .expire_o (gap_expire)
    );

    pv_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .rd_vld_i      (rd_vld_i),
        .dec_i         (dec),
        .gap_zero_i    (gap_zero),
        .gap_expire_i  (gap_expire),
        .phase_o       (phase),
        .accept_o      (accept),
        .issue_o       (issue),
        .gap_load_o    (gap_load),
        .finish_o      (finish),
        .finish_pass_o (finish_pass)
    );

    assign rd_req_o = issue;

    // Result registers: cleared on accept, loaded on finish, done pulses once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
            fail_o <= 1'b0;
            data_o <= '0;
        end else begin
            done_o <= finish;
            if (accept) begin
                pass_o <= 1'b0;
                fail_o <= 1'b0;
            end else if (finish) begin
                pass_o <= finish_pass;
                fail_o <= !finish_pass;
                data_o <= rd_data_i;
            end
        end
    end

endmodule

// File: rtl/poll_verifier_chk.sv
// Module: poll_verifier_chk
// Port-level checker bound to poll_verifier; keeps its own view of busy and outstanding reads.
// Assumes: the read port returns one response per request.
module poll_verifier_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] addr_i,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_vld_i,
    input logic          done_o,
    input logic          pass_o,
    input logic          fail_o
);

    logic          busy_q, outst_q;
    logic [AW-1:0] addr_q;
    logic          idle_now;

    assign idle_now = !busy_q || done_o;

    // Track job occupancy and the address taken at accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
        end else if (idle_now && start_i) begin
            busy_q <= 1'b1;
            addr_q <= addr_i;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end
    end

    // Track whether a response is still owed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (rd_req_o) begin
            outst_q <= 1'b1;
        end else if (rd_vld_i) begin
            outst_q <= 1'b0;
        end
    end

    // R10
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !outst_q);

    // R2
    read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o == addr_q));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    // R8
    done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o != fail_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && !done_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));

endmodule

bind poll_verifier poll_verifier_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_vld_i  (rd_vld_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
);

// File: tb/poll_verifier_tb.sv
`timescale 1ns/1ps
// Bench: behavioural status model plus a cycle-by-cycle reference model.
module poll_verifier_tb;

    localparam int AW = 16;
    localparam int GW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    exp_byte_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [GW-1:0] gap_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_vld_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          done_o, pass_o, fail_o;
    logic [7:0]    data_o;

    poll_verifier #(.AW(AW), .GW(GW)) u_dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Status model state
    logic [7:0] stat_q[$];
    int lat   = 1;
    int pend  = -1;
    int reads = 0;

    // Reference model state
    bit         m_busy, m_wait, m_req, m_done, m_pass, m_fail;
    int         m_phase, m_gapleft, m_gap;
    logic [7:0] m_exp, m_data;
    logic [AW-1:0] m_addr;

    function automatic void m_next();
        if (m_gap == 0) m_req = 1;
        else m_gapleft = m_gap;
    endfunction

    // Reference model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_wait = 0; m_req = 0; m_done = 0; m_pass = 0; m_fail = 0;
            m_phase = 0; m_gapleft = 0; m_gap = 0; m_exp = 0; m_data = 0; m_addr = 0;
        end else begin
            m_done = 0;
            if (m_req) begin
                m_req = 0; m_wait = 1;
            end else if (m_wait) begin
                if (rd_vld_i) begin
                    m_wait = 0;
                    if (m_phase == 2) begin
                        m_done = 1; m_pass = 1; m_busy = 0; m_data = rd_data_i;
                    end else if (rd_data_i[7] == m_exp[7]) begin
                        m_phase = 2; m_next();
                    end else if (m_phase == 1) begin
                        m_done = 1; m_fail = 1; m_busy = 0; m_data = rd_data_i;
                    end else if (rd_data_i[5]) begin
                        m_phase = 1; m_next();
                    end else begin
                        m_next();
                    end
                end
            end else if (m_gapleft > 0) begin
                m_gapleft--;
                if (m_gapleft == 0) m_req = 1;
            end else if (!m_busy && start_i) begin
                m_busy = 1; m_exp = exp_byte_i; m_gap = int'(gap_i); m_addr = addr_i;
                m_pass = 0; m_fail = 0; m_phase = 0; m_req = 1;
            end
        end
    end

    // Compare against the model, then run the status model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_req_o == m_req, "R7", "rd_req_o", rd_req_o, m_req);
            if (m_req) chk(rd_addr_o == m_addr, "R2", "rd_addr_o", rd_addr_o, m_addr);
            chk(done_o == m_done, "R8", "done_o", done_o, m_done);
            chk(pass_o == m_pass, "R3", "pass_o", pass_o, m_pass);
            chk(fail_o == m_fail, "R5", "fail_o", fail_o, m_fail);
            chk(data_o == m_data, "R6", "data_o", data_o, m_data);
        end
        rd_vld_i = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rd_vld_i  = 1'b1;
                rd_data_i = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
                pend = -1;
            end
        end
        if (rd_req_o) begin
            chk(pend == -1 && !rd_vld_i, "R10", "read while pending", pend, -1);
            reads++;
            pend = lat;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    task automatic run(input logic [7:0] expb, input logic [AW-1:0] adr, input int gap,
                       input int l, input logic [7:0] seq[$], input bit exp_pass,
                       input logic [7:0] exp_data, input int exp_reads, input string tag);
        stat_q = seq; lat = l; reads = 0;
        @(negedge clk);
        exp_byte_i = expb; addr_i = adr; gap_i = GW'(gap); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!pass_o && !fail_o, "R8", "result cleared after start", {pass_o, fail_o}, 0);
        wait_done();
        chk(pass_o == exp_pass, tag, "pass_o", pass_o, exp_pass);
        chk(fail_o == !exp_pass, tag, "fail_o", fail_o, !exp_pass);
        chk(data_o == exp_data, tag, "data_o", data_o, exp_data);
        chk(reads == exp_reads, tag, "read count", reads, exp_reads);
        @(negedge clk);
        chk(!done_o, "R8", "done_o one cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rd_req_o && !done_o && !pass_o && !fail_o && data_o == 8'h00, "R1",
            "reset outputs", {rd_req_o, done_o, pass_o, fail_o, data_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R6: first poll matches, gap 0
        run(8'h80, 16'h1234, 0, 1, '{8'h80, 8'h83}, 1'b1, 8'h83, 2, "R6");
        // R4 R7: three retries with gap 3, latency 2
        run(8'h00, 16'h0040, 3, 2, '{8'h80, 8'h80, 8'h80, 8'h00, 8'h11}, 1'b1, 8'h11, 5, "R4");
        // R5: erase, time limit set, recheck passes
        run(8'hFF, 16'h7000, 1, 1, '{8'h00, 8'h20, 8'hA0, 8'hFF}, 1'b1, 8'hFF, 4, "R5");
        // R5: recheck mismatch gives fail
        run(8'h7F, 16'h0101, 2, 3, '{8'hA0, 8'hA4}, 1'b0, 8'hA4, 2, "R5");
        repeat (6) @(negedge clk);
        chk(fail_o && !pass_o, "R8", "fail held", {pass_o, fail_o}, 1);

        // R9: start while busy is ignored
        stat_q = '{8'h00, 8'h00, 8'h80, 8'h42}; lat = 3; reads = 0;
        @(negedge clk);
        exp_byte_i = 8'h80; addr_i = 16'h2222; gap_i = 8'd4; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        exp_byte_i = 8'h00; addr_i = 16'hBEEF; gap_i = 8'd0; start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(pass_o && data_o == 8'h42, "R9", "result of first job", data_o, 8'h42);
        repeat (8) @(negedge clk);
        chk(reads == 4, "R9", "no extra job", reads, 4);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule